// File: doc/BRIEF.md
# Phosphor byte store controller

This block keeps one byte in eight light-charged phosphor cells. Each cell has a charging LED output and a phototransistor sense input. A cell that is charged glows and reads as 1. Its glow fades over time, and the only way to clear it is to wait in the dark. The controller turns these slow, leaky cells into a byte that a CPU can read and write. It signals `busy` whenever the value cannot be served, so the bus can stall the processor.

A write is captured when the write strobe falls. The controller then switches every LED off and waits until all eight sensed bits read zero. If the new byte is zero, it settles in a plain readable state that needs no refresh. Otherwise it passes through one transition cycle, lights the LEDs of the 1 bits for a fixed charge period, and passes through a second transition cycle. It then serves reads until a refresh period expires and recharges the lit bits. Time is counted in cycles of the CPU clock, which drives `clk`.

The write side is a plain strobe and has no back-pressure. `busy` is the only stall indication, and a strobe that falls while `busy` is high restarts the store sequence. The read side offers `rd_valid` with no ready, because a read never consumes anything. Sense inputs pass through a two-flop synchroniser before any use.

Top module: `phos_mem_ctrl`

## Requirements
- R1: While `rst_n` is low, and after it is released, the block is in the idle readable state: `led` = 0, `busy` = 0, `rd_valid` = 1, and the stored byte is 0.
- R2: When `wr_strobe` is 1 in one cycle and 0 in the next, the block captures `wr_data` at that clock edge. From the following cycle it is in the erase state with `busy` = 1.
- R3: In the erase state `led` = 0 and `busy` = 1. The block stays in the erase state while the synchronised sense byte is non-zero.
- R4: When the erase state sees a synchronised sense byte of 0 and the stored byte is 0, the next state is idle, with `busy` = 0 and no charge.
- R5: When the erase state sees a synchronised sense byte of 0 and the stored byte is non-zero, the block spends exactly one cycle in a transition state (`busy` = 1, `led` = 0) and then charges.
- R6: In the charge state `led` equals the stored byte, with bit i driving cell i. `busy` = 1, and the state lasts exactly CHARGE_TICKS cycles.
- R7: After the charge state the block spends exactly one transition cycle (`busy` = 1, `led` = 0) and then enters the hold state, where `busy` = 0.
- R8: After exactly REFRESH_TICKS cycles in the hold state, the block returns directly to the charge state without erasing.
- R9: The idle state never starts a refresh. It is left only through a write.
- R10: `rd_valid` is 1 exactly in the idle and hold states. There `rd_data` equals the `sense` input delayed by two clock cycles. Otherwise `rd_data` = 0.
- R11: A falling strobe in any state, including charge, transition and hold, restarts the sequence at erase with the new byte.
- R12: While `wr_strobe` stays high, the state and outputs are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock; one cycle is one tick |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_strobe | input | 1 | Write strobe; the falling edge commits `wr_data` |
| wr_data | input | 8 | Byte to store |
| sense | input | 8 | Raw phototransistor bits, asynchronous |
| led | output | 8 | Charging LED drive, one per cell |
| busy | output | 1 | High while the byte cannot be served |
| rd_valid | output | 1 | `rd_data` carries the stored byte |
| rd_data | output | 8 | Synchronised sense byte |

## Verification
A wrong state shows at the ports within one cycle. `busy` separates the readable states from the busy ones, and `led` separates charge from the transitions and the erase. A timer that runs off by a single cycle moves the fall of `busy` or the edges of `led` by that cycle. The bench therefore compares every output against a behavioural model on every clock, so such an error is reported in the cycle where it first appears. Sense changes and strobes placed during each state expose wrong priority or synchroniser depth within two cycles.

// File: rtl/phos_pkg.sv
package phos_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_ERASE  = 3'd1,
    ST_PRECHG = 3'd2,
    ST_CHARGE = 3'd3,
    ST_POSTCH = 3'd4,
    ST_HOLD   = 3'd5
  } phos_state_e;
endpackage

// File: rtl/phos_sense_sync.sv
module phos_sense_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage_q [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= '0;
        else if (g == 0) stage_q[g] <= din;
        else stage_q[g] <= stage_q[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/phos_tick_timer.sv
module phos_tick_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [CNT_W-1:0] limit,
  output logic             done
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (clr) cnt_q <= '0;
    else          cnt_q <= cnt_q + 1'b1;
  end

  assign done = (cnt_q == limit - 1'b1);
endmodule

// File: rtl/phos_mem_ctrl.sv
module phos_mem_ctrl #(
  parameter int unsigned WIDTH         = 8,
  parameter int unsigned CHARGE_TICKS  = 4_000_000,
  parameter int unsigned REFRESH_TICKS = 8_000_000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_strobe,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [WIDTH-1:0] sense,
  output logic [WIDTH-1:0] led,
  output logic             busy,
  output logic             rd_valid,
  output logic [WIDTH-1:0] rd_data
);
  import phos_pkg::*;

  localparam int unsigned MAX_TICKS = (CHARGE_TICKS > REFRESH_TICKS) ? CHARGE_TICKS : REFRESH_TICKS;
  localparam int unsigned CNT_W     = $clog2(MAX_TICKS + 1);
  localparam logic [CNT_W-1:0] CHG_LIM = CNT_W'(CHARGE_TICKS);
  localparam logic [CNT_W-1:0] REF_LIM = CNT_W'(REFRESH_TICKS);

  phos_state_e      state_q;
  logic [WIDTH-1:0] stored_q;
  logic [WIDTH-1:0] sense_s;
  logic             strb_q;
  logic             wr_fall;
  logic             tmr_clr;
  logic             tmr_done;
  logic [CNT_W-1:0] tmr_limit;

  phos_sense_sync #(.WIDTH(WIDTH), .STAGES(2)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (sense),
    .dout (sense_s)
  );

  assign tmr_limit = (state_q == ST_CHARGE) ? CHG_LIM : REF_LIM;
  assign tmr_clr   = wr_fall || tmr_done ||
                     !((state_q == ST_CHARGE) || (state_q == ST_HOLD));

  phos_tick_timer #(.CNT_W(CNT_W)) u_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (tmr_clr),
    .limit(tmr_limit),
    .done (tmr_done)
  );

  assign wr_fall = strb_q && !wr_strobe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strb_q <= 1'b0;
    else        strb_q <= wr_strobe;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      stored_q <= '0;
    end else if (wr_fall) begin
      state_q  <= ST_ERASE;
      stored_q <= wr_data;
    end else begin
      unique case (state_q)
        ST_IDLE:   state_q <= ST_IDLE;
        ST_ERASE:  if (sense_s == '0) state_q <= (stored_q == '0) ? ST_IDLE : ST_PRECHG;
        ST_PRECHG: state_q <= ST_CHARGE;
        ST_CHARGE: if (tmr_done) state_q <= ST_POSTCH;
        ST_POSTCH: state_q <= ST_HOLD;
        ST_HOLD:   if (tmr_done) state_q <= ST_CHARGE;
        default:   state_q <= ST_IDLE;
      endcase
    end
  end

  assign led      = (state_q == ST_CHARGE) ? stored_q : '0;
  assign busy     = (state_q == ST_ERASE) || (state_q == ST_PRECHG) ||
                    (state_q == ST_CHARGE) || (state_q == ST_POSTCH);
  assign rd_valid = !busy;
  assign rd_data  = rd_valid ? sense_s : '0;

  // R2
  wr_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fall |=> (state_q == ST_ERASE) && (stored_q == $past(wr_data)));
  // R3
  erase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ERASE) && (sense_s != '0) && !wr_fall |=> state_q == ST_ERASE);
  // R5
  prechg_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PRECHG) && !wr_fall |=> state_q == ST_CHARGE);
  // R6
  charge_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CHARGE) && tmr_done && !wr_fall |=> state_q == ST_POSTCH);
  // R8
  refresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HOLD) && tmr_done && !wr_fall |=> state_q == ST_CHARGE);
  // R9
  idle_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) && !wr_fall |=> state_q == ST_IDLE);
  // R12
  strobe_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_strobe && $past(wr_strobe) |=> $stable(stored_q));
endmodule

// File: tb/phos_mem_ctrl_tb.sv
module phos_mem_ctrl_tb;
  localparam int CH = 6;
  localparam int RF = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_strobe = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] sense = '0;
  logic [7:0] led;
  logic       busy;
  logic       rd_valid;
  logic [7:0] rd_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  phos_mem_ctrl #(.WIDTH(8), .CHARGE_TICKS(CH), .REFRESH_TICKS(RF)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_strobe(wr_strobe), .wr_data(wr_data),
    .sense(sense), .led(led), .busy(busy), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  // behavioural reference: state number 0..5, tick count, delayed sense queue
  int         m_st = 0;
  int         m_cnt = 0;
  logic [7:0] m_byte = '0;
  logic       m_strb = 1'b0;
  logic [7:0] m_dly [$] = '{8'h00, 8'h00};

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_byte = '0; m_strb = 1'b0;
      m_dly = '{8'h00, 8'h00};
    end else begin
      logic [7:0] seen;
      seen = m_dly[0];
      if (m_strb && !wr_strobe) begin
        m_byte = wr_data; m_st = 1; m_cnt = 0;
      end else begin
        case (m_st)
          1: if (seen == 0) m_st = (m_byte == 0) ? 0 : 2;
          2: begin m_st = 3; m_cnt = 0; end
          3: if (m_cnt == CH-1) begin m_st = 4; m_cnt = 0; end else m_cnt++;
          4: begin m_st = 5; m_cnt = 0; end
          5: if (m_cnt == RF-1) begin m_st = 3; m_cnt = 0; end else m_cnt++;
          default: ;
        endcase
      end
      m_strb = wr_strobe;
      void'(m_dly.pop_front());
      m_dly.push_back(sense);
    end
  end

  function automatic string tag_of(int s);
    case (s)
      0: return "R9";  1: return "R3";  2: return "R5";
      3: return "R6";  4: return "R7";  default: return "R8";
    endcase
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s at %0t: actual %0h expected %0h", req, $time, act, exp);
    end
  endtask

  task automatic compare();
    bit         m_busy;
    logic [7:0] m_led;
    if (!rst_n) return;
    m_busy = (m_st >= 1 && m_st <= 4);
    m_led  = (m_st == 3) ? m_byte : 8'h00;
    check({tag_of(m_st), " led"},  led,  m_led);
    check({tag_of(m_st), " busy"}, busy, m_busy);
    check("R10 rd_valid", rd_valid, !m_busy);
    check("R10 rd_data",  rd_data,  m_busy ? 0 : m_dly[0]);
  endtask

  task automatic cyc(int n);
    repeat (n) begin @(negedge clk); compare(); end
  endtask

  task automatic write(logic [7:0] d, int hold);
    wr_data = d; wr_strobe = 1'b1;
    cyc(hold);
    wr_strobe = 1'b0;
    cyc(1);
    // R2: busy rises the cycle after the strobe falls
    check("R2 busy after write", busy, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state while held
    check("R1 led", led, 0); check("R1 busy", busy, 0); check("R1 rd_valid", rd_valid, 1);
    rst_n = 1'b1;
    cyc(1);
    check("R1 after release", {led, busy}, 0);
    // R9: idle with a zero byte never refreshes
    cyc(3 * RF);
    check("R9 idle busy", busy, 0);
    // R10: readable value follows sense in idle
    sense = 8'h11; cyc(3); sense = 8'h00; cyc(3);
    // R2 R3: stale glow keeps the erase waiting
    sense = 8'h3C;
    write(8'hA5, 2);
    cyc(6);
    check("R3 erase holds", busy, 1);
    check("R3 leds dark", led, 0);
    sense = 8'h00;
    cyc(2);
    // R5 R6: transition then charge of the 1 bits
    cyc(2);
    check("R6 charging", led, 8'hA5);
    sense = 8'hA5;
    // R7 R8: hold, then two refresh rounds
    cyc(CH + 2 * (RF + CH + 1));
    // R11: write during charge restarts at erase
    wait (led != 0); @(negedge clk); compare();
    write(8'h5A, 1);
    check("R11 leds off", led, 0);
    sense = 8'h00;
    cyc(CH + RF + 6);
    // R12: strobe held high changes nothing
    sense = 8'h5A;
    wr_data = 8'hFF; wr_strobe = 1'b1;
    cyc(RF + 4);
    // R11 R4: falling during hold with zero byte, erase back to idle
    sense = 8'h0F;
    wr_data = 8'h00; wr_strobe = 1'b0;
    cyc(1);
    check("R11 erase from hold", busy, 1);
    cyc(3);
    sense = 8'h00;
    cyc(4);
    check("R4 idle after zero write", {busy, led}, 0);
    cyc(2 * RF);
    // R1: reset mid-charge
    write(8'h81, 1);
    cyc(5);
    rst_n = 1'b0; cyc(1); @(negedge clk);
    check("R1 reset led", led, 0); check("R1 reset busy", busy, 0);
    rst_n = 1'b1; cyc(4);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule